// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block runs on the host side of a flash device. It decides whether a program or erase operation inside the device has finished, and it does this by watching a status bit that changes on every read while the operation is still running. A one-cycle start strobe launches the polling sequence. The block then reads the device's status byte over a simple request/acknowledge bus and compares the toggle bit across back-to-back reads. It also inspects the device's timeout flag.

When the toggle bit stays still, the operation has completed. When the timeout flag is set while the bit is still moving, the block does not fail at once. It takes a further pair of reads, because the toggling can stop in the same read in which the flag rises. Only a toggle that persists through this recheck counts as a failure. In that case the block writes the device's reset command and waits for it to be acknowledged before it finishes.

The result is a one-cycle done strobe and a pass flag. The pass flag keeps its value until the next poll finishes.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: While reset is held and right after it is released, busy, done, pass and the bus request are all 0.
- R2: A start seen while idle makes busy 1 and raises a read request (write-enable 0, address equal to the configured poll address) on the next cycle.
- R3: Once raised, a request and its direction stay unchanged until the cycle in which acknowledge is 1. The read byte is captured in that acknowledge cycle, and each acknowledge completes exactly one transfer.
- R4: Reads come in pairs. If bit 6 is equal in the two bytes of a pair, the cycle after the second acknowledge shows done=1 and pass=1, and no write was issued.
- R5: If bit 6 differs within a pair and bit 5 of the second byte is 0, a new pair of reads follows.
- R6: If bit 6 differs within a pair and bit 5 of the second byte is 1, exactly one further pair of reads is taken. If bit 6 is equal in that pair, the poll ends with pass=1.
- R7: If bit 6 still differs in the recheck pair, one write of 0xF0 to the poll address is issued. After its acknowledge, done=1 with pass=0.
- R8: Done is high for a single cycle, and pass changes only in a cycle in which done is 1.
- R9: A start asserted while busy has no effect: no extra transfer is issued and no second poll follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a poll (taken only when idle) |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion strobe |
| pass_o | output | 1 | 1 = operation complete, 0 = failure; held between polls |
| mem_req_o | output | 1 | Bus transfer request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Transfer address |
| mem_wdata_o | output | 8 | Write data (reset command) |
| mem_ack_i | input | 1 | Transfer acknowledge |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |

## Verification
Several rules are checked by the in-RTL properties on every clock:
- a request with its direction is held until it is acknowledged;
- a start seen while idle leads to a read request on the next cycle;
- done is a one-cycle pulse, and pass moves only with done;
- a failing done is always preceded by an acknowledged write;
- a passing done is always preceded by an acknowledged read.

The bench's scripted byte sequences are needed for the decisions themselves:
- how many reads each toggle and timeout pattern costs;
- that the recheck pair turns a timeout into a pass when the toggling stops;
- that the reset command carries 0xF0 to the poll address;
- that a start held through a whole poll launches nothing more.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_A  = 3'd1,
    ST_RD_B  = 3'd2,
    ST_RE_A  = 3'd3,
    ST_RE_B  = 3'd4,
    ST_CMD   = 3'd5
  } tpoll_state_e;

  localparam int unsigned TPOLL_DATA_W = 8;

endpackage

// File: rtl/tpoll_status_eval.sv
module tpoll_status_eval #(
  parameter int DATA_W      = 8,
  parameter int TOGGLE_BIT  = 6,
  parameter int TIMEOUT_BIT = 5
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ref_bit_i,
  output logic              toggled_o,
  output logic              timed_out_o
);

  // Toggle detection against the bit captured from the previous read
  always_comb begin
    toggled_o   = rdata_i[TOGGLE_BIT] ^ ref_bit_i;
    timed_out_o = rdata_i[TIMEOUT_BIT];
  end

endmodule

// File: rtl/tpoll_bus_drv.sv
module tpoll_bus_drv
  import tpoll_pkg::*;
#(
  parameter int                 ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  POLL_ADDR = '0,
  parameter logic [7:0]         RESET_CMD = 8'hF0
) (
  input  tpoll_state_e      state_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o
);

  // Bus outputs decode directly from the registered state
  always_comb begin
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = POLL_ADDR;
    wdata_o = '0;
    unique case (state_i)
      ST_RD_A, ST_RD_B, ST_RE_A, ST_RE_B: req_o = 1'b1;
      ST_CMD: begin
        req_o   = 1'b1;
        we_o    = 1'b1;
        wdata_o = RESET_CMD;
      end
      default: req_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/tpoll_result_reg.sv
module tpoll_result_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic fin_en_i,
  input  logic fin_pass_i,
  output logic done_o,
  output logic pass_o
);

  logic done_d, pass_d;

  always_comb begin
    done_d = fin_en_i;
    pass_d = fin_en_i ? fin_pass_i : pass_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= done_d;
      pass_o <= pass_d;
    end
  end

  // R8: completion strobe never spans two cycles
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: outcome flag only moves together with the strobe
  p_pass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(pass_o));

endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
  import tpoll_pkg::*;
#(
  parameter int                 ADDR_W      = 16,
  parameter logic [ADDR_W-1:0]  POLL_ADDR   = '0,
  parameter logic [7:0]         RESET_CMD   = 8'hF0,
  parameter int                 TOGGLE_BIT  = 6,
  parameter int                 TIMEOUT_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [7:0]        mem_rdata_i
);

  localparam int DATA_W = TPOLL_DATA_W;

  tpoll_state_e state_q, state_d;
  logic         ref_q, ref_en;
  logic         toggled, timed_out;
  logic         fin_en, fin_pass;

  tpoll_status_eval #(
    .DATA_W     (DATA_W),
    .TOGGLE_BIT (TOGGLE_BIT),
    .TIMEOUT_BIT(TIMEOUT_BIT)
  ) i_eval (
    .rdata_i    (mem_rdata_i),
    .ref_bit_i  (ref_q),
    .toggled_o  (toggled),
    .timed_out_o(timed_out)
  );

  tpoll_bus_drv #(
    .ADDR_W   (ADDR_W),
    .POLL_ADDR(POLL_ADDR),
    .RESET_CMD(RESET_CMD)
  ) i_bus (
    .state_i(state_q),
    .req_o  (mem_req_o),
    .we_o   (mem_we_o),
    .addr_o (mem_addr_o),
    .wdata_o(mem_wdata_o)
  );

  tpoll_result_reg i_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_en_i  (fin_en),
    .fin_pass_i(fin_pass),
    .done_o    (done_o),
    .pass_o    (pass_o)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    ref_en   = 1'b0;
    fin_en   = 1'b0;
    fin_pass = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RD_A;
      ST_RD_A: if (mem_ack_i) begin
        ref_en  = 1'b1;
        state_d = ST_RD_B;
      end
      ST_RD_B: if (mem_ack_i) begin
        if (!toggled) begin
          fin_en   = 1'b1;
          fin_pass = 1'b1;
          state_d  = ST_IDLE;
        end else if (timed_out) begin
          state_d = ST_RE_A;
        end else begin
          state_d = ST_RD_A;
        end
      end
      ST_RE_A: if (mem_ack_i) begin
        ref_en  = 1'b1;
        state_d = ST_RE_B;
      end
      ST_RE_B: if (mem_ack_i) begin
        if (!toggled) begin
          fin_en   = 1'b1;
          fin_pass = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          state_d = ST_CMD;
        end
      end
      ST_CMD: if (mem_ack_i) begin
        fin_en   = 1'b1;
        fin_pass = 1'b0;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // Reference toggle bit, loaded on the first read of each pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= 1'b0;
    else if (ref_en) ref_q <= mem_rdata_i[TOGGLE_BIT];
  end

  always_comb busy_o = (state_q != ST_IDLE);

  // R3: a pending transfer is held steady until acknowledged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_we_o));

  // R2: an accepted start turns into a read request
  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && start_i |=> mem_req_o && !mem_we_o);

  // R7: a failing result follows an acknowledged write
  p_fail_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !pass_o |-> $past(mem_req_o && mem_we_o && mem_ack_i));

  // R4: a passing result follows an acknowledged read
  p_pass_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && pass_o |-> $past(mem_req_o && !mem_we_o && mem_ack_i));

  // R9: without an acknowledge a busy poll stays busy whatever start does
  p_busy_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !mem_ack_i |=> busy_o);

endmodule

// File: tb/test_toggle_poll_ctrl.sv
`timescale 1ns/1ps
module test_toggle_poll_ctrl;

  localparam int              AW = 16;
  localparam logic [AW-1:0]   PA = 16'h0AA0;

  logic          clk = 1'b0;
  logic          rst_n, start, ack;
  logic [7:0]    rdata;
  logic          busy, done, pass, req, we;
  logic [AW-1:0] addr;
  logic [7:0]    wdata;

  always #2 clk = ~clk;

  toggle_poll_ctrl #(.ADDR_W(AW), .POLL_ADDR(PA)) i_toggle_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
    .done_o(done), .pass_o(pass), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_ack_i(ack),
    .mem_rdata_i(rdata)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Responder and per-cycle monitor state
  logic [7:0] feed[$];
  int  lat_sel = 0, wait_cnt = 0;
  int  n_rd = 0, n_wr = 0, addr_err = 0, hold_err = 0, wdata_err = 0;
  int  pulse_err = 0, pass_err = 0;
  bit  done_prev = 0, pass_prev = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      ack <= 1'b0; rdata <= 8'h00; wait_cnt = 0;
    end else begin
      if (done_prev && done) pulse_err++;
      if ((pass != pass_prev) && !done) pass_err++;
      done_prev = done;
      pass_prev = pass;
      if (ack) begin
        ack <= 1'b0;
        wait_cnt = 0;
      end else if (req) begin
        if (wait_cnt >= (lat_sel % 4)) begin
          ack <= 1'b1;
          if (addr != PA) addr_err++;
          if (we) begin
            n_wr++;
            if (wdata != 8'hF0) wdata_err++;
          end else begin
            n_rd++;
            rdata <= (feed.size() > 0) ? feed.pop_front() : 8'h00;
          end
          lat_sel++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else if (wait_cnt > 0) begin
        hold_err++;
      end
    end
  end

  // Behavioural reference: expected reads, write and outcome for a byte script
  task automatic predict(input logic [7:0] s[$], output int rd,
                         output bit wr, output bit ok);
    int i = 0;
    logic [7:0] a, b;
    rd = 0; wr = 0; ok = 0;
    while (i + 1 < s.size()) begin
      a = s[i]; b = s[i+1]; i += 2; rd += 2;
      if (a[6] == b[6]) begin ok = 1; return; end
      if (b[5]) begin
        a = s[i]; b = s[i+1]; rd += 2;
        if (a[6] == b[6]) ok = 1; else wr = 1;
        return;
      end
    end
  endtask

  task automatic run(input string rq, input logic [7:0] s[$], input bit hold_start);
    int  exp_rd, cyc;
    bit  exp_wr, exp_ok;
    predict(s, exp_rd, exp_wr, exp_ok);
    feed = s; n_rd = 0; n_wr = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) if (!hold_start) start = 1'b0;
    chk(busy && req && !we && addr == PA, "R2", "start->read req", {busy, req, we}, 3'b110);
    chk(pass == pass_prev, "R8", "pass held at start", pass, pass_prev);
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, rq, "watchdog done", done, 1);
    chk(pass == exp_ok, rq, "pass", pass, exp_ok);
    chk(n_rd == exp_rd, rq, "read count", n_rd, exp_rd);
    chk(n_wr == int'(exp_wr), rq, "write count", n_wr, exp_wr);
    @(negedge clk);
    chk(!done, "R8", "done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(!busy && !req, hold_start ? "R9" : rq, "idle after poll", {busy, req}, 0);
    chk(n_rd == exp_rd, hold_start ? "R9" : rq, "no extra reads", n_rd, exp_rd);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, pass, req} == 4'b0, "R1", "outputs in reset", {busy, done, pass, req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, pass, req} == 4'b0, "R1", "outputs after reset", {busy, done, pass, req}, 0);

    run("R4", '{8'h00, 8'h00}, 0);
    run("R5", '{8'h40, 8'h00, 8'h00, 8'h40, 8'h40, 8'h40}, 0);
    run("R6", '{8'h00, 8'h60, 8'h60, 8'h60}, 0);
    run("R7", '{8'h00, 8'h60, 8'h20, 8'h60}, 0);
    run("R4", '{8'h00, 8'h20}, 0);
    run("R6", '{8'h40, 8'h20, 8'h00, 8'h00}, 0);
    run("R7", '{8'h40, 8'h00, 8'h00, 8'h40, 8'h00, 8'h60, 8'h60, 8'h20}, 1);
    run("R9", '{8'h00, 8'h40, 8'h40, 8'h40}, 1);

    chk(addr_err == 0, "R2", "transfer address", addr_err, 0);
    chk(wdata_err == 0, "R7", "reset command data", wdata_err, 0);
    chk(hold_err == 0, "R3", "request held until ack", hold_err, 0);
    chk(pulse_err == 0, "R8", "done pulse width", pulse_err, 0);
    chk(pass_err == 0, "R8", "pass moves only with done", pass_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule